// File: doc/BRIEF.md
# Single-Cycle RV32I Integer Core

This block is a processor core that completes one RV32I base integer instruction per clock: register-register and register-immediate arithmetic, logic, shifts and compares, LUI, AUIPC, the six conditional branches, JAL and JALR. Loads, stores, system instructions and fences are not executed. The core sends a word address to an external instruction memory and expects the 32-bit instruction back combinationally in the same cycle. In that cycle it decodes the instruction, reads two source registers, computes a result or a branch decision, writes the destination register and loads the next program counter.

A debug read port returns any architectural register by index, and the current program counter is also visible on an output. A testbench or a surrounding system loads a program into the instruction memory, releases reset and watches the state through these two outputs.

Top module: `rv_core`

## Requirements
- R1: While reset is high the program counter and the instruction address read zero, and every register clears to zero.
- R2: An instruction that takes no branch or jump advances the program counter by 4; the instruction address equals the program counter divided by 4.
- R3: Register x0 reads zero on every port at all times; an instruction naming x0 as its destination changes no register.
- R4: Major opcode 00100 (bits [6:2]) performs add, set-less-than signed (funct3 010), set-less-than unsigned (011), xor (100), or (110), and (111) and shifts (001 left, 101 right, arithmetic when bit 30 is set) with the sign-extended 12-bit immediate from bits [31:20].
- R5: Major opcode 01100 performs the same eight operations on two registers; with funct3 000 or 101, bit 30 set selects subtract or arithmetic right shift.
- R6: Opcode 01101 writes the U immediate (bits [31:12] over twelve zeros); opcode 00101 writes the program counter plus the U immediate.
- R7: Opcode 11000 compares rs1 and rs2 by funct3 (000 equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110 unsigned less, 111 unsigned greater-or-equal) and, when true, jumps to the program counter plus the sign-extended B immediate; it writes no register.
- R8: Opcode 11011 writes the program counter plus 4 and jumps to the program counter plus the sign-extended J immediate.
- R9: Opcode 11001 writes the program counter plus 4 and jumps to rs1 plus the I immediate with bit 0 cleared.
- R10: An instruction with any other major opcode, or whose bits [1:0] are not 11, writes no register and advances the program counter by 4.
- R11: A loop summing 1 through 9 leaves 45 in x14 and sets the pass flag register within 50 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | IMEM_AW | Word address of the instruction to fetch |
| imem_rdata | input | 32 | Instruction word returned for imem_addr |
| dbg_pc | output | 32 | Current program counter |
| dbg_rsel | input | 5 | Register index for the debug read |
| dbg_rdata | output | 32 | Value of the register at dbg_rsel |

## Verification
Assertions check on every cycle that x0 reads zero, the program counter stays word aligned and is zero after reset, sequential flow adds exactly 4, a taken branch lands on the program counter plus its offset, the JALR target is even, link writes carry the return address and unrecognised opcodes never enable a write. The values the ALU produces, the correct branch sense for each condition code and the end result of whole programs show only in the bench's scenarios, where a behavioural instruction-set model runs alongside the core and the program counter and last-written register are compared every clock.

// File: rtl/rv_core_pkg.sv
package rv_core_pkg;

  localparam int XLEN = 32;
  localparam int RIDX = 5;

  typedef enum logic [4:0] {
    OPC_OPIMM  = 5'b00100,
    OPC_AUIPC  = 5'b00101,
    OPC_STORE  = 5'b01000,
    OPC_OP     = 5'b01100,
    OPC_LUI    = 5'b01101,
    OPC_BRANCH = 5'b11000,
    OPC_JALR   = 5'b11001,
    OPC_JAL    = 5'b11011
  } opc_e;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND
  } alu_op_e;

  typedef enum logic [1:0] { A_RS1, A_PC, A_ZERO } a_sel_e;

  typedef enum logic [2:0] { FMT_I, FMT_S, FMT_B, FMT_U, FMT_J } imm_fmt_e;

  typedef struct packed {
    logic            known;
    logic            rd_valid;
    logic [RIDX-1:0] rd;
    logic [RIDX-1:0] rs1;
    logic [RIDX-1:0] rs2;
    logic [2:0]      f3;
    logic [XLEN-1:0] imm;
    alu_op_e         alu_op;
    a_sel_e          a_sel;
    logic            b_imm;
    logic            is_branch;
    logic            is_jal;
    logic            is_jalr;
  } dec_t;

  function automatic logic [XLEN-1:0] make_imm(input logic [31:0] ins, input imm_fmt_e fmt);
    case (fmt)
      FMT_I:   return {{21{ins[31]}}, ins[30:20]};
      FMT_S:   return {{21{ins[31]}}, ins[30:25], ins[11:7]};
      FMT_B:   return {{20{ins[31]}}, ins[7], ins[30:25], ins[11:8], 1'b0};
      FMT_U:   return {ins[31:12], 12'b0};
      default: return {{12{ins[31]}}, ins[19:12], ins[20], ins[30:21], 1'b0};
    endcase
  endfunction

  function automatic logic [XLEN-1:0] alu_calc(input alu_op_e op, input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (op)
      ALU_ADD:  return a + b;
      ALU_SUB:  return a - b;
      ALU_SLL:  return a << b[4:0];
      ALU_SLT:  return {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
      ALU_SLTU: return {{(XLEN-1){1'b0}}, a < b};
      ALU_XOR:  return a ^ b;
      ALU_SRL:  return a >> b[4:0];
      ALU_SRA:  return $unsigned($signed(a) >>> b[4:0]);
      ALU_OR:   return a | b;
      default:  return a & b;
    endcase
  endfunction

  function automatic logic branch_true(input logic [2:0] f3, input logic [XLEN-1:0] a,
                                       input logic [XLEN-1:0] b);
    case (f3)
      3'b000:  return a == b;
      3'b001:  return a != b;
      3'b100:  return $signed(a) < $signed(b);
      3'b101:  return $signed(a) >= $signed(b);
      3'b110:  return a < b;
      3'b111:  return a >= b;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rv_decode.sv
module rv_decode
  import rv_core_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);

  opc_e     opc;
  imm_fmt_e fmt;
  alu_op_e  f3_op;

  assign opc = opc_e'(instr[6:2]);

  always_comb begin
    case (instr[14:12])
      3'b000:  f3_op = (opc == OPC_OP && instr[30]) ? ALU_SUB : ALU_ADD;
      3'b001:  f3_op = ALU_SLL;
      3'b010:  f3_op = ALU_SLT;
      3'b011:  f3_op = ALU_SLTU;
      3'b100:  f3_op = ALU_XOR;
      3'b101:  f3_op = instr[30] ? ALU_SRA : ALU_SRL;
      3'b110:  f3_op = ALU_OR;
      default: f3_op = ALU_AND;
    endcase
  end

  always_comb begin
    case (opc)
      OPC_LUI, OPC_AUIPC: fmt = FMT_U;
      OPC_BRANCH:         fmt = FMT_B;
      OPC_JAL:            fmt = FMT_J;
      OPC_STORE:          fmt = FMT_S;
      default:            fmt = FMT_I;
    endcase
  end

  always_comb begin
    dec           = '0;
    dec.rd        = instr[11:7];
    dec.rs1       = instr[19:15];
    dec.rs2       = instr[24:20];
    dec.f3        = instr[14:12];
    dec.imm       = make_imm(instr, fmt);
    dec.alu_op    = ALU_ADD;
    dec.a_sel     = A_RS1;
    dec.b_imm     = 1'b1;
    if (instr[1:0] == 2'b11) begin
      case (opc)
        OPC_OPIMM:  begin dec.known = 1'b1; dec.rd_valid = 1'b1; dec.alu_op = f3_op; end
        OPC_OP:     begin dec.known = 1'b1; dec.rd_valid = 1'b1; dec.alu_op = f3_op;
                          dec.b_imm = 1'b0; end
        OPC_LUI:    begin dec.known = 1'b1; dec.rd_valid = 1'b1; dec.a_sel = A_ZERO; end
        OPC_AUIPC:  begin dec.known = 1'b1; dec.rd_valid = 1'b1; dec.a_sel = A_PC; end
        OPC_BRANCH: begin dec.known = 1'b1; dec.is_branch = 1'b1; dec.b_imm = 1'b0; end
        OPC_JAL:    begin dec.known = 1'b1; dec.rd_valid = 1'b1; dec.is_jal = 1'b1; end
        OPC_JALR:   begin dec.known = 1'b1; dec.rd_valid = 1'b1; dec.is_jalr = 1'b1; end
        default:    dec.known = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/rv_regfile.sv
module rv_regfile #(
  parameter int NREG = 32,
  parameter int XLEN = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   ra_addr,
  output logic [XLEN-1:0] ra_data,
  input  logic [AW-1:0]   rb_addr,
  output logic [XLEN-1:0] rb_data,
  input  logic [AW-1:0]   rc_addr,
  output logic [XLEN-1:0] rc_data,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata
);

  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
  assign rc_data = mem[rc_addr];

  // R3: the zero register must read zero on every port
  p_zero_reads_r3: assert property (@(posedge clk) disable iff (rst)
    (rc_addr == '0) |-> (rc_data == '0));
  p_zero_reads_a_r3: assert property (@(posedge clk) disable iff (rst)
    (ra_addr == '0) |-> (ra_data == '0));

endmodule

// File: rtl/rv_nextpc.sv
module rv_nextpc
  import rv_core_pkg::*;
(
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  dec_t            dec,
  output logic            taken_br,
  output logic            redirect,
  output logic [XLEN-1:0] pc_plus4,
  output logic [XLEN-1:0] next_pc
);

  logic [XLEN-1:0] rel_tgt, jalr_tgt;

  assign pc_plus4 = pc + 32'd4;
  assign rel_tgt  = pc + dec.imm;
  assign jalr_tgt = (rs1_val + dec.imm) & ~32'd1;
  assign taken_br = dec.is_branch && branch_true(dec.f3, rs1_val, rs2_val);
  assign redirect = taken_br || dec.is_jal || dec.is_jalr;

  always_comb begin
    if (taken_br)         next_pc = rel_tgt;
    else if (dec.is_jal)  next_pc = rel_tgt;
    else if (dec.is_jalr) next_pc = jalr_tgt;
    else                  next_pc = pc_plus4;
  end

endmodule

// File: rtl/rv_core.sv
module rv_core
  import rv_core_pkg::*;
#(
  parameter int IMEM_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  output logic [IMEM_AW-1:0] imem_addr,
  input  logic [31:0]        imem_rdata,
  output logic [31:0]        dbg_pc,
  input  logic [4:0]         dbg_rsel,
  output logic [31:0]        dbg_rdata
);

  logic [XLEN-1:0] pc_q, pc_nx, pc_plus4;
  logic [XLEN-1:0] rs1_val, rs2_val, alu_a, alu_b, alu_res, wb_data;
  logic            rf_we, taken_br, redirect;
  dec_t            dec;

  assign imem_addr = pc_q[IMEM_AW+1:2];
  assign dbg_pc    = pc_q;

  rv_decode u_dec (.instr(imem_rdata), .dec(dec));

  rv_regfile #(.NREG(32), .XLEN(XLEN)) u_rf (
    .clk(clk), .rst(rst),
    .ra_addr(dec.rs1), .ra_data(rs1_val),
    .rb_addr(dec.rs2), .rb_data(rs2_val),
    .rc_addr(dbg_rsel), .rc_data(dbg_rdata),
    .we(rf_we), .waddr(dec.rd), .wdata(wb_data)
  );

  rv_nextpc u_npc (
    .pc(pc_q), .rs1_val(rs1_val), .rs2_val(rs2_val), .dec(dec),
    .taken_br(taken_br), .redirect(redirect), .pc_plus4(pc_plus4), .next_pc(pc_nx)
  );

  always_comb begin
    case (dec.a_sel)
      A_PC:    alu_a = pc_q;
      A_ZERO:  alu_a = '0;
      default: alu_a = rs1_val;
    endcase
  end

  assign alu_b   = dec.b_imm ? dec.imm : rs2_val;
  assign alu_res = alu_calc(dec.alu_op, alu_a, alu_b);
  assign wb_data = (dec.is_jal || dec.is_jalr) ? pc_plus4 : alu_res;
  assign rf_we   = dec.rd_valid && (dec.rd != '0);

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nx;
  end

  // R1: first cycle after reset fetches from address zero
  p_pc_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc_q == '0));
  // R2: program counter stays word aligned
  p_pc_align_r2: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00);
  // R2: no redirect means plain increment by one word
  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> (pc_q == $past(pc_q) + 32'd4));
  // R7: a taken branch lands at pc plus offset
  p_br_target_r7: assert property (@(posedge clk) disable iff (rst)
    taken_br |=> (pc_q == $past(pc_q) + $past(dec.imm)));
  // R7: branches never write a register
  p_br_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
    dec.is_branch |-> !rf_we);
  // R9: register-indirect target is even
  p_jalr_even_r9: assert property (@(posedge clk) disable iff (rst)
    dec.is_jalr |-> (pc_nx[0] == 1'b0));
  // R8: link value is the return address
  p_link_r8: assert property (@(posedge clk) disable iff (rst)
    (rf_we && (dec.is_jal || dec.is_jalr)) |-> (wb_data == pc_q + 32'd4));
  // R10: unrecognised instructions never write
  p_unknown_nowrite_r10: assert property (@(posedge clk) disable iff (rst)
    !dec.known |-> (!rf_we && !redirect));

endmodule

// File: tb/rv_core_test.sv
module rv_core_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] imem_addr;
  logic [31:0]   imem_rdata;
  logic [31:0]   dbg_pc;
  logic [4:0]    dbg_rsel = '0;
  logic [31:0]   dbg_rdata;

  logic [31:0] prog [256];
  logic [31:0] mreg [32];
  logic [31:0] mpc;
  string       ptag, rtag;
  int          checks = 0, failures = 0, cyc = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign imem_rdata = prog[imem_addr];

  rv_core #(.IMEM_AW(AW)) uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dbg_pc(dbg_pc), .dbg_rsel(dbg_rsel), .dbg_rdata(dbg_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // encoders
  function automatic logic [31:0] e_i(input logic [6:0] op, input int rd, input int f3,
                                      input int rs1, input int imm);
    logic [31:0] v = imm;
    return {v[11:0], 5'(rs1), 3'(f3), 5'(rd), op};
  endfunction
  function automatic logic [31:0] e_r(input int f7, input int rs2, input int rs1, input int f3,
                                      input int rd);
    return {7'(f7), 5'(rs2), 5'(rs1), 3'(f3), 5'(rd), 7'b0110011};
  endfunction
  function automatic logic [31:0] e_b(input int f3, input int rs1, input int rs2, input int off);
    logic [31:0] v = off;
    return {v[12], v[10:5], 5'(rs2), 5'(rs1), 3'(f3), v[4:1], v[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] e_u(input logic [6:0] op, input int rd, input int up);
    logic [31:0] v = up;
    return {v[19:0], 5'(rd), op};
  endfunction
  function automatic logic [31:0] e_j(input int rd, input int off);
    logic [31:0] v = off;
    return {v[20], v[10:1], v[11], v[19:12], 5'(rd), 7'b1101111};
  endfunction
  function automatic logic [31:0] addi(input int rd, input int rs1, input int imm);
    return e_i(7'b0010011, rd, 0, rs1, imm);
  endfunction

  // behavioural reference: one instruction
  function automatic logic [31:0] ref_op(input int f3, input bit alt, input logic [31:0] a,
                                         input logic [31:0] b);
    int sa = b[4:0];
    case (f3)
      0: return alt ? a - b : a + b;
      1: return a << sa;
      2: return ($signed(a) < $signed(b)) ? 1 : 0;
      3: return (a < b) ? 1 : 0;
      4: return a ^ b;
      5: return alt ? $unsigned($signed(a) >>> sa) : a >> sa;
      6: return a | b;
      default: return a & b;
    endcase
  endfunction

  task automatic model_step();
    logic [31:0] ins = prog[mpc[AW+1:2]];
    logic [31:0] a = mreg[ins[19:15]];
    logic [31:0] b = mreg[ins[24:20]];
    logic [31:0] ii = {{20{ins[31]}}, ins[31:20]};
    logic [31:0] bi = {{19{ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
    logic [31:0] ji = {{11{ins[31]}}, ins[31], ins[19:12], ins[20], ins[30:21], 1'b0};
    logic [31:0] ui = {ins[31:12], 12'b0};
    logic [31:0] res = '0, npc = mpc + 4;
    int f3 = ins[14:12];
    bit wr = 0, cond;
    ptag = "R2"; rtag = "R10";
    case (ins[6:0])
      7'h13: begin wr = 1; rtag = "R4"; res = ref_op(f3, ins[30] && f3 == 5, a, ii); end
      7'h33: begin wr = 1; rtag = "R5"; res = ref_op(f3, ins[30], a, b); end
      7'h37: begin wr = 1; rtag = "R6"; res = ui; end
      7'h17: begin wr = 1; rtag = "R6"; res = mpc + ui; end
      7'h6f: begin wr = 1; rtag = "R8"; ptag = "R8"; res = mpc + 4; npc = mpc + ji; end
      7'h67: begin wr = 1; rtag = "R9"; ptag = "R9"; res = mpc + 4; npc = (a + ii) & ~32'd1; end
      7'h63: begin
        rtag = "R7"; ptag = "R7";
        case (f3)
          0: cond = a == b;
          1: cond = a != b;
          4: cond = $signed(a) < $signed(b);
          5: cond = $signed(a) >= $signed(b);
          6: cond = a < b;
          7: cond = a >= b;
          default: cond = 0;
        endcase
        if (cond) npc = mpc + bi;
      end
      default: ptag = "R10";
    endcase
    if (ins[11:7] == 0 && wr) rtag = "R3";
    if (wr && ins[11:7] != 0) mreg[ins[11:7]] = res;
    mpc = npc;
    dbg_rsel = ins[11:7];
  endtask

  task automatic run(input int ncyc);
    rst = 1;
    mpc = 0;
    foreach (mreg[i]) mreg[i] = '0;
    ptag = "R1"; rtag = "R1";
    dbg_rsel = 5'd14;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 pc in reset", dbg_pc, 32'd0);
    check("R1 fetch address in reset", 32'(imem_addr), 32'd0);
    check("R1 register cleared", dbg_rdata, 32'd0);
    rst = 0;
    for (int c = 0; c < ncyc; c++) begin
      check({ptag, " pc"}, dbg_pc, mpc);
      check({rtag, " written register"}, dbg_rdata, mreg[dbg_rsel]);
      model_step();
      @(negedge clk);
    end
  endtask

  task automatic peek(input string tag, input int r, input logic [31:0] exp);
    dbg_rsel = 5'(r);
    #1;
    check(tag, dbg_rdata, exp);
  endtask

  initial begin
    foreach (prog[i]) prog[i] = addi(0, 0, 0);
    // program A: sum 1..9
    prog[0]  = addi(12, 0, 10);
    prog[1]  = addi(13, 0, 1);
    prog[2]  = addi(14, 0, 0);
    prog[3]  = e_r(0, 13, 14, 0, 14);
    prog[4]  = addi(13, 13, 1);
    prog[5]  = e_b(4, 13, 12, -8);
    prog[6]  = addi(15, 0, 45);
    prog[7]  = e_b(1, 14, 15, 12);
    prog[8]  = addi(30, 0, 1);
    prog[9]  = e_j(0, 0);
    prog[10] = addi(31, 0, 1);
    prog[11] = e_j(0, 0);
    run(50);
    peek("R11 sum in x14", 14, 32'd45);
    peek("R11 pass flag x30", 30, 32'd1);
    peek("R11 fail flag x31", 31, 32'd0);

    // program B: operation coverage
    foreach (prog[i]) prog[i] = addi(0, 0, 0);
    prog[0]  = addi(1, 0, -5);
    prog[1]  = addi(2, 0, 3);
    prog[2]  = e_r(0, 2, 1, 0, 3);
    prog[3]  = e_r(32, 1, 2, 0, 4);
    prog[4]  = e_r(0, 2, 1, 1, 5);
    prog[5]  = e_r(0, 2, 1, 2, 6);
    prog[6]  = e_r(0, 2, 1, 3, 7);
    prog[7]  = e_r(0, 2, 1, 4, 8);
    prog[8]  = e_r(0, 2, 1, 5, 9);
    prog[9]  = e_r(32, 2, 1, 5, 10);
    prog[10] = e_r(0, 2, 1, 6, 11);
    prog[11] = e_r(0, 2, 1, 7, 12);
    prog[12] = e_i(7'b0010011, 13, 2, 1, -4);
    prog[13] = e_i(7'b0010011, 14, 3, 2, -1);
    prog[14] = e_i(7'b0010011, 15, 4, 1, -1);
    prog[15] = e_i(7'b0010011, 16, 6, 2, 'h7f0);
    prog[16] = e_i(7'b0010011, 17, 7, 1, 'h0ff);
    prog[17] = e_i(7'b0010011, 18, 1, 2, 31);
    prog[18] = e_i(7'b0010011, 19, 5, 1, 4);
    prog[19] = e_i(7'b0010011, 20, 5, 1, 'h404);
    prog[20] = e_u(7'b0110111, 21, 'hABCDE);
    prog[21] = e_u(7'b0010111, 22, 1);
    prog[22] = addi(0, 0, 123);
    prog[23] = {7'd0, 5'd2, 5'd1, 3'b010, 5'd23, 7'b0100011};
    prog[24] = e_b(0, 1, 1, 8);
    prog[25] = addi(24, 0, 1);
    prog[26] = e_b(1, 1, 1, 8);
    prog[27] = e_b(4, 1, 2, 8);
    prog[28] = addi(24, 0, 2);
    prog[29] = e_b(5, 1, 2, 8);
    prog[30] = e_b(6, 1, 2, 8);
    prog[31] = e_b(7, 1, 2, 8);
    prog[32] = addi(24, 0, 3);
    prog[33] = e_j(25, 8);
    prog[34] = addi(24, 0, 4);
    prog[35] = addi(26, 0, 153);
    prog[36] = e_i(7'b1100111, 27, 0, 26, 0);
    prog[37] = addi(24, 0, 5);
    prog[38] = e_b(0, 0, 0, 8);
    prog[39] = addi(24, 0, 6);
    prog[40] = e_j(0, 0);
    prog[41] = 32'h0000_0BB0;
    run(60);
    for (int r = 0; r < 32; r++) peek(r == 0 ? "R3 x0 after write attempt" : "R5 register sweep", r, mreg[r]);
    peek("R5 add", 3, 32'hFFFF_FFFE);
    peek("R5 sub", 4, 32'd8);
    peek("R5 sra", 10, 32'hFFFF_FFFF);
    peek("R5 sltu", 7, 32'd0);
    peek("R4 slti", 13, 32'd1);
    peek("R4 srli", 19, 32'h0FFF_FFFF);
    peek("R4 srai", 20, 32'hFFFF_FFFF);
    peek("R6 lui", 21, 32'hABCD_E000);
    peek("R6 auipc", 22, 32'd4180);
    peek("R7 skipped instructions", 24, 32'd0);
    peek("R8 jal link", 25, 32'd136);
    peek("R9 jalr link", 27, 32'd148);
    peek("R10 store-class writes nothing", 23, 32'd0);
    check("R8 final self loop", dbg_pc, 32'd160);

    // R10: low bits not 11 behave as no-op
    foreach (prog[i]) prog[i] = addi(0, 0, 0);
    prog[0] = addi(5, 0, 7);
    prog[1] = addi(5, 0, 9) & ~32'd1;
    prog[2] = e_j(0, 0);
    run(6);
    peek("R10 bad low bits ignored", 5, 32'd7);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc >= WATCHDOG);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule